// File: doc/BRIEF.md
# Four-Way Cache Victim Selector

This block chooses which way of a four-way set-associative cache is replaced on the next fill. It keeps a small recency record for every set and updates that record whenever a way in the set is touched, whether by a hit or by a fill. The tag and data arrays live elsewhere. The block only sees which set is addressed, which way was touched, and which ways of that set hold valid lines.

A build-time parameter selects one of two policies. The exact policy keeps one ordering bit for each of the six pairs of ways. From these bits the complete recency order can be recovered, and the victim is the way used least recently. The cheaper policy keeps a three-node binary tree. Each node bit steers the victim search into one half, and each access turns the bits on its path away from the touched way. Under either policy, an empty way is always filled before any valid line is evicted.

Top module: `way_victim_sel`

## Requirements
- R1: After reset, every set reports victim way 0 when all four ways are valid, under both policies.
- R2: When `way_valid` has any bit at 0, `victim_way` is the lowest-numbered way whose valid bit is 0, whatever the recency state holds.
- R3: In pairwise mode (`POLICY` = 0), with all ways valid, `victim_way` is the way of the set whose most recent access is oldest. Before any access, the initial order ranks way 3 as most recent and way 0 as least recent.
- R4: In the cycle after an access to way k of a set, with all ways valid, that set does not report k as victim. This holds in both modes.
- R5: An access to one set leaves the victim of every other set unchanged.
- R6: In tree mode (`POLICY` = 1), the root bit at 0 selects ways 0/1 and at 1 selects ways 2/3. The chosen leaf bit at 0 selects the lower way of that pair and at 1 selects the upper way. An access to way k sets the root and k's leaf bit to point away from k. After an access to way k, the victim lies in the other half (`victim_way[1]` differs from k[1]).
- R7: While `acc_en` is 0, no recency state changes, whatever `set_idx` and `acc_way` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| acc_en | input | 1 | Access strobe: a hit or a fill touched `acc_way` of set `set_idx` this cycle |
| set_idx | input | SET_W | Set addressed for both the update and the victim lookup |
| acc_way | input | 2 | Way touched by the access |
| way_valid | input | 4 | Valid bits of the four ways in set `set_idx` |
| victim_way | output | 2 | Way to replace on the next fill of set `set_idx` |

## Verification
The assertions assume that `set_idx` and `way_valid` describe the same set in a given cycle, and that a way is reported valid only once it has been filled. They also assume that the "victim after an access" properties are judged only when the following cycle still addresses the same set with all ways valid. The bench keeps to these assumptions. It drives one set at a time, changes inputs only at the falling edge, and samples victims with all ways valid except in the dedicated empty-way sweeps, which present every valid mask. A bench model tracks an access timestamp per way and the tree bits per set. Random access streams over all sets run against this model, followed by directed orderings and idle stretches.

// File: rtl/victim_sel_pkg.sv
package victim_sel_pkg;
  localparam int WAYS      = 4;
  localparam int WAY_W     = 2;
  localparam int PAIR_BITS = WAYS * (WAYS - 1) / 2;
  localparam int TREE_BITS = WAYS - 1;

  typedef logic [WAY_W-1:0] way_t;

  typedef enum logic {
    POL_PAIR_LRU  = 1'b0,
    POL_TREE_PLRU = 1'b1
  } policy_e;

  // slot of the ordering bit for ways lo < hi
  function automatic int pair_slot(input int lo, input int hi);
    return lo * (2 * WAYS - 1 - lo) / 2 + (hi - lo - 1);
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pair_order_policy.sv
module pair_order_policy
  import victim_sel_pkg::*;
(
  input  logic [PAIR_BITS-1:0] cur_bits,
  input  way_t                 hit_way,
  output logic [PAIR_BITS-1:0] next_bits,
  output way_t                 oldest_way
);
  logic [WAYS-1:0] is_oldest;

  // bit (lo,hi) = 1 : lo more recent than hi
  genvar gi, gj;
  generate
    for (gi = 0; gi < WAYS; gi++) begin : g_lo
      for (gj = gi + 1; gj < WAYS; gj++) begin : g_hi
        localparam int SLOT = pair_slot(gi, gj);
        assign next_bits[SLOT] = (hit_way == way_t'(gi)) ? 1'b1 :
                                 (hit_way == way_t'(gj)) ? 1'b0 :
                                 cur_bits[SLOT];
      end
    end
  endgenerate

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      is_oldest[w] = 1'b1;
      for (int o = 0; o < WAYS; o++) begin
        if (o < w)      is_oldest[w] = is_oldest[w] &  cur_bits[pair_slot(o, w)];
        else if (o > w) is_oldest[w] = is_oldest[w] & ~cur_bits[pair_slot(w, o)];
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (is_oldest[w]) oldest_way = way_t'(w);
    end
  end
endmodule

// File: rtl/tree_policy.sv
module tree_policy
  import victim_sel_pkg::*;
(
  input  logic [TREE_BITS-1:0] cur_bits,  // [0] root, [1] ways 0/1, [2] ways 2/3
  input  way_t                 hit_way,
  output logic [TREE_BITS-1:0] next_bits,
  output way_t                 pick_way
);
  always_comb begin
    next_bits    = cur_bits;
    next_bits[0] = ~hit_way[1];
    if (!hit_way[1]) next_bits[1] = ~hit_way[0];
    else             next_bits[2] = ~hit_way[0];
  end

  assign pick_way = cur_bits[0] ? {1'b1, cur_bits[2]} : {1'b0, cur_bits[1]};
endmodule

// File: rtl/invalid_first.sv
module invalid_first
  import victim_sel_pkg::*;
(
  input  logic [WAYS-1:0] way_valid,
  input  way_t            policy_way,
  output way_t            victim_way
);
  always_comb begin
    victim_way = policy_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) victim_way = way_t'(w);
    end
  end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
  import victim_sel_pkg::*;
#(
  parameter int      SETS   = 8,
  parameter policy_e POLICY = POL_PAIR_LRU,
  localparam int     SET_W  = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic [SET_W-1:0] set_idx,
  input  logic [1:0]       acc_way,
  input  logic [3:0]       way_valid,
  output logic [1:0]       victim_way
);
  localparam int ROW_W = (POLICY == POL_PAIR_LRU) ? PAIR_BITS : TREE_BITS;

  logic             rst_q_n;
  logic [ROW_W-1:0] row_q [SETS];
  logic [ROW_W-1:0] row_cur;
  logic [ROW_W-1:0] row_nxt;
  way_t             pol_way;

  rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  assign row_cur = row_q[set_idx];

  generate
    if (POLICY == POL_PAIR_LRU) begin : g_pair
      pair_order_policy u_pol (
        .cur_bits   (row_cur),
        .hit_way    (acc_way),
        .next_bits  (row_nxt),
        .oldest_way (pol_way)
      );
    end else begin : g_tree
      tree_policy u_pol (
        .cur_bits  (row_cur),
        .hit_way   (acc_way),
        .next_bits (row_nxt),
        .pick_way  (pol_way)
      );

      assert_tree_other_half_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
        acc_en |=> (set_idx != $past(set_idx) || way_valid != 4'hF ||
                    victim_way[1] != $past(acc_way[1])));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      for (int s = 0; s < SETS; s++) row_q[s] <= '0;
    end else if (acc_en) begin
      row_q[set_idx] <= row_nxt;
    end
  end

  invalid_first u_pick (
    .way_valid  (way_valid),
    .policy_way (pol_way),
    .victim_way (victim_way)
  );

  assert_empty_way_first_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (way_valid != 4'hF) |->
      (!way_valid[victim_way] &&
       ((way_valid & ((4'd1 << victim_way) - 4'd1)) == ((4'd1 << victim_way) - 4'd1))));

  assert_touched_not_victim_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    acc_en |=> (set_idx != $past(set_idx) || way_valid != 4'hF ||
                victim_way != $past(acc_way)));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !acc_en |=> (!$stable(set_idx) || !$stable(way_valid) || $stable(victim_way)));
endmodule

// File: tb/test_way_victim_sel.sv
`timescale 1ns/1ps
module test_way_victim_sel;
  localparam int SETS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0;
  logic [2:0] set_idx = '0;
  logic [1:0] acc_way = '0;
  logic [3:0] way_valid = 4'hF;
  logic [1:0] vic_lru, vic_tree;

  int checks = 0;
  int errors = 0;
  int stamp [SETS][4];
  int tick;
  logic [2:0] tb_tree [SETS];

  always #2.5 clk = ~clk;

  way_victim_sel #(.SETS(SETS), .POLICY(victim_sel_pkg::POL_PAIR_LRU)) i_way_victim_sel (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .set_idx(set_idx),
    .acc_way(acc_way), .way_valid(way_valid), .victim_way(vic_lru));

  way_victim_sel #(.SETS(SETS), .POLICY(victim_sel_pkg::POL_TREE_PLRU)) i_way_victim_sel_tree (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .set_idx(set_idx),
    .acc_way(acc_way), .way_valid(way_valid), .victim_way(vic_tree));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lru_exp(input int s);
    int best = 0;
    for (int w = 1; w < 4; w++) if (stamp[s][w] < stamp[s][best]) best = w;
    return best;
  endfunction

  function automatic int tree_exp(input int s);
    if (tb_tree[s][0]) return 2 + int'(tb_tree[s][2]);
    return int'(tb_tree[s][1]);
  endfunction

  function automatic int masked(input int pol, input logic [3:0] m);
    int r = pol;
    for (int w = 3; w >= 0; w--) if (!m[w]) r = w;
    return r;
  endfunction

  task automatic model_reset;
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < 4; w++) stamp[s][w] = w;  // way 3 newest, way 0 oldest
      tb_tree[s] = 3'b000;
    end
    tick = 4;
  endtask

  task automatic model_touch(input int s, input int w);
    stamp[s][w] = tick;
    tick++;
    tb_tree[s][0] = (w < 2);          // root points to the other half
    if (w < 2) tb_tree[s][1] = (w == 0);
    else       tb_tree[s][2] = (w == 2);
  endtask

  task automatic do_access(input int s, input int w);
    @(negedge clk);
    acc_en = 1'b1; set_idx = 3'(s); acc_way = 2'(w); way_valid = 4'hF;
    @(posedge clk);
    #1;
    model_touch(s, w);
  endtask

  task automatic look(input int s, input logic [3:0] m);
    @(negedge clk);
    acc_en = 1'b0; set_idx = 3'(s); way_valid = m;
    #1;
  endtask

  task automatic check_set(input string lru_tag, input string tree_tag,
                           input int s, input logic [3:0] m);
    look(s, m);
    chk($sformatf("%s pair set=%0d mask=%h", lru_tag, s, m), int'(vic_lru), masked(lru_exp(s), m));
    chk($sformatf("%s tree set=%0d mask=%h", tree_tag, s, m), int'(vic_tree), masked(tree_exp(s), m));
  endtask

  task automatic access_and_check(input int s, input int w);
    do_access(s, w);
    check_set("R3", "R6", s, 4'hF);
    chk($sformatf("R4 pair touched way %0d not victim", w), int'(vic_lru != 2'(w)), 1);
    chk($sformatf("R4 tree touched way %0d not victim", w), int'(vic_tree != 2'(w)), 1);
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < SETS; s++) check_set(tag, tag, s, 4'hF);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    model_reset();

    // R1: reset state
    for (int s = 0; s < SETS; s++) begin
      look(s, 4'hF);
      chk($sformatf("R1 pair set=%0d", s), int'(vic_lru), 0);
      chk($sformatf("R1 tree set=%0d", s), int'(vic_tree), 0);
    end

    // R2: every valid mask on a fresh set
    for (int m = 0; m < 15; m++) check_set("R2", "R2", 0, 4'(m));

    // R3 / R6 directed ordering on set 1: 2,0,3,1 -> both pick way 2
    do_access(1, 2); do_access(1, 0); do_access(1, 3); do_access(1, 1);
    look(1, 4'hF);
    chk("R3 pair order 2,0,3,1", int'(vic_lru), 2);
    chk("R6 tree order 2,0,3,1", int'(vic_tree), 2);

    // R6 single access to way 0 of set 2 -> root right, right leaf 0 -> way 2
    do_access(2, 0);
    look(2, 4'hF);
    chk("R6 tree after way 0", int'(vic_tree), 2);
    chk("R3 pair after way 0", int'(vic_lru), 1);

    // R5: hammer one set, others untouched
    for (int i = 0; i < 20; i++) do_access(3, i % 4);
    check_all("R5");

    // random streams
    for (int i = 0; i < 1500; i++) begin
      access_and_check(int'($urandom % SETS), int'($urandom % 4));
      if (i % 100 == 99) begin
        check_all("R5");
        for (int m = 0; m < 15; m++) check_set("R2", "R2", int'($urandom % SETS), 4'(m));
      end
    end

    // R7: idle cycles with noisy inputs
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      acc_en = 1'b0;
      set_idx = 3'($urandom % SETS);
      acc_way = 2'($urandom % 4);
      way_valid = 4'($urandom);
    end
    check_all("R7");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule